// File: doc/BRIEF.md
# CIC Interpolation Filter

This block raises the sample rate of a stream of signed scalar samples by an integer factor using a cascaded integrator-comb structure. Each accepted input sample first passes through N comb sections with differential delay M, running at the input rate. The block then expands the sample into R output phases: the comb result in the first phase and zeros in the remaining R-1. These phases feed N integrator sections that run at the output rate. While a burst is in progress the block delivers one output sample per clock.

The factor R is either a fixed parameter or, in variable-rate mode, a 12-bit value presented with each sample and clamped to 1..RMAX. A `ready` output tells the source when the next sample may be offered. A synchronous `srst` input abandons any burst in flight and clears every register. The output carries either the full-precision result (input width plus gain bits) or only its upper bits, truncated back to the input width.

Top module: `cic_interp`

## Requirements
- R1: For every accepted sample, the output sequence equals N comb stages (y = x - x delayed by M accepted samples), followed by zero stuffing to R phases, followed by N running-sum integrators. All stages are computed modulo 2^IW.
- R2: A sample is taken only in a cycle where `valid_in` is 1, `srst` is 0 and `ready` was 1 in the previous cycle. In any other cycle, `data_in` and `rate_in` have no effect on the outputs.
- R3: If a sample is accepted in cycle t, `valid_out` is 1 in cycles t+2 through t+R+1 and 0 in every other cycle. No run of `valid_out` is longer than RMAX cycles.
- R4: `ready` is 0 in the accept cycle t and in cycles t+1 through t+R-1. It is 1 from cycle t+R until the next accept. It is 0 in any cycle where `srst` is 1.
- R5: When VAR_RATE=1, R is taken from `rate_in` in the accept cycle and applies to that sample's burst. A value of 0 is treated as 1, and a value above RMAX is treated as RMAX. When VAR_RATE=0, R is the parameter R_FIX.
- R6: `srst` is synchronous. In the cycle after it is sampled high, `valid_out` is 0 and `data_out` is 0. Any burst in progress is dropped, and later samples are filtered from an all-zero state.
- R7: In full-precision mode (FULL_PREC=1), the output width is IW = DW + ceil(log2((RMAX*M)^N / RMAX)). A full-scale DC input of -2^(DW-1) settles to -2^(DW-1)*(R*M)^N/R without error.
- R8: In truncated mode (FULL_PREC=0), `data_out` is DW bits wide and equals bits IW-1 down to IW-DW of the full-precision result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous clear, active high |
| data_in | input | DW | Signed input sample |
| valid_in | input | 1 | Input sample offered |
| rate_in | input | 12 | Runtime interpolation factor (variable-rate mode) |
| ready | output | 1 | Next-cycle input will be accepted |
| data_out | output | IW or DW | Signed output sample |
| valid_out | output | 1 | Output sample present |

## Verification
The hardest situation to reach is a reset that arrives in the middle of a burst whose factor was chosen at runtime, while the source keeps `valid_in` high through cycles in which `ready` is low. The stimulus holds `valid_in` asserted across whole bursts with changing samples and rates, so that many offers are refused. It fires `srst` a few phases into a long burst and then restarts with a different factor, including the clamped values 0 and 15. A behavioural model predicts every `ready`, `valid_out` and data value in every cycle. A full-scale DC run checks that the width headroom is exact.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Bit growth of the interpolator: ceil(log2((rmax*m)^n / rmax))
    function automatic int gain_bits(input int rmax, input int m, input int n);
        longint p;
        int     g;
        p = 1;
        for (int i = 0; i < n; i++) begin
            p = p * longint'(rmax * m);
        end
        p = p / longint'(rmax);
        g = 0;
        while ((longint'(1) << g) < p) begin
            g++;
        end
        return g;
    endfunction

endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl #(
    parameter int RMAX     = 8,
    parameter int VAR_RATE = 1,
    parameter int R_FIX    = 8,
    parameter int CW       = 4
) (
    input  logic        clk,
    input  logic        srst,
    input  logic        valid_in,
    input  logic [11:0] rate_in,
    output logic        accept,
    output logic        ready,
    output logic        step,
    output logic        first,
    output logic        valid_out
);

    typedef struct packed {
        logic          busy;
        logic          acc_en;
        logic          vout;
        logic [CW-1:0] cnt;
        logic [CW-1:0] rate;
    } ctrl_t;

    ctrl_t         st_d, st_q;
    logic [CW-1:0] rate_sel;
    logic          last;

    generate
        if (VAR_RATE != 0) begin : g_var
            always_comb begin
                if (rate_in == 12'd0) begin
                    rate_sel = CW'(1);
                end else if (rate_in > 12'(RMAX)) begin
                    rate_sel = CW'(RMAX);
                end else begin
                    rate_sel = rate_in[CW-1:0];
                end
            end
        end else begin : g_fix
            assign rate_sel = CW'(R_FIX);
        end
    endgenerate

    assign last      = st_q.busy && (st_q.cnt == st_q.rate - CW'(1));
    assign accept    = valid_in && st_q.acc_en && !srst;
    assign ready     = !srst && !accept && (!st_q.busy || last);
    assign step      = st_q.busy;
    assign first     = st_q.busy && (st_q.cnt == '0);
    assign valid_out = st_q.vout;

    always_comb begin
        st_d        = st_q;
        st_d.acc_en = ready;
        st_d.vout   = st_q.busy;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.rate = rate_sel;
        end else if (st_q.busy) begin
            if (last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        if (srst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int DW = 16,
    parameter int IW = 25,
    parameter int N  = 3,
    parameter int M  = 2
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          en,
    input  logic [DW-1:0] x,
    output logic [IW-1:0] y
);

    typedef struct packed {
        logic [N*M-1:0][IW-1:0] dly;
    } comb_t;

    comb_t               st_d, st_q;
    logic [N:0][IW-1:0]  tap;

    always_comb begin
        tap[0] = {{(IW-DW){x[DW-1]}}, x};
        for (int i = 0; i < N; i++) begin
            tap[i+1] = tap[i] - st_q.dly[i*M + M - 1];
        end
        st_d = st_q;
        if (en) begin
            for (int i = 0; i < N; i++) begin
                for (int j = M - 1; j > 0; j--) begin
                    st_d.dly[i*M + j] = st_q.dly[i*M + j - 1];
                end
                st_d.dly[i*M] = tap[i];
            end
        end
        if (srst) begin
            st_d = '0;
        end
    end

    assign y = tap[N];

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int IW = 25,
    parameter int N  = 3
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          step,
    input  logic [IW-1:0] x,
    output logic [IW-1:0] y
);

    typedef struct packed {
        logic [N-1:0][IW-1:0] acc;
    } integ_t;

    integ_t              st_d, st_q;
    logic [N:0][IW-1:0]  sum;

    always_comb begin
        sum[0] = x;
        st_d   = st_q;
        for (int i = 0; i < N; i++) begin
            sum[i+1] = st_q.acc[i] + sum[i];
            if (step) begin
                st_d.acc[i] = sum[i+1];
            end
        end
        if (srst) begin
            st_d = '0;
        end
    end

    assign y = st_q.acc[N-1];

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/cic_interp.sv
module cic_interp
    import cic_pkg::*;
#(
    parameter int DW        = 16,
    parameter int N         = 3,
    parameter int M         = 2,
    parameter int RMAX      = 8,
    parameter int VAR_RATE  = 1,
    parameter int R_FIX     = 8,
    parameter int FULL_PREC = 1
) (
    input  logic        clk,
    input  logic        srst,
    input  logic [DW-1:0] data_in,
    input  logic        valid_in,
    input  logic [11:0] rate_in,
    output logic        ready,
    output logic [((FULL_PREC != 0) ? (DW + gain_bits(RMAX, M, N)) : DW)-1:0] data_out,
    output logic        valid_out
);

    localparam int GB = gain_bits(RMAX, M, N);
    localparam int IW = DW + GB;
    localparam int CW = $clog2(RMAX + 1);

    typedef struct packed {
        logic [IW-1:0] up;
    } top_t;

    top_t          st_d, st_q;
    logic          accept, step, first;
    logic [IW-1:0] comb_y, stuffed, integ_y;

    cic_ctrl #(
        .RMAX(RMAX), .VAR_RATE(VAR_RATE), .R_FIX(R_FIX), .CW(CW)
    ) u_ctrl (
        .clk(clk), .srst(srst), .valid_in(valid_in), .rate_in(rate_in),
        .accept(accept), .ready(ready), .step(step), .first(first),
        .valid_out(valid_out)
    );

    cic_comb_chain #(.DW(DW), .IW(IW), .N(N), .M(M)) u_comb (
        .clk(clk), .srst(srst), .en(accept), .x(data_in), .y(comb_y)
    );

    // Hold the comb result for the first output phase; others see zero.
    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.up = comb_y;
        end
        if (srst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stuffed = first ? st_q.up : '0;

    cic_integ_chain #(.IW(IW), .N(N)) u_integ (
        .clk(clk), .srst(srst), .step(step), .x(stuffed), .y(integ_y)
    );

    generate
        if (FULL_PREC != 0) begin : g_full
            assign data_out = integ_y;
        end else begin : g_trunc
            assign data_out = integ_y[IW-1 -: DW];
        end
    endgenerate

endmodule

module cic_interp_chk #(
    parameter int RMAX = 8
) (
    input logic clk,
    input logic srst,
    input logic ready,
    input logic valid_out,
    input logic accept,
    input logic dout_zero
);

    int run_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            run_q <= 0;
        end else begin
            run_q <= valid_out ? run_q + 1 : 0;
        end
    end

    assert_accept_after_ready_R2: assert property (@(posedge clk) disable iff (srst)
        accept |-> $past(ready));

    assert_burst_start_R3: assert property (@(posedge clk) disable iff (srst)
        accept |=> ##1 valid_out);

    assert_run_length_R3: assert property (@(posedge clk) disable iff (srst)
        valid_out |-> (run_q < RMAX));

    assert_single_accept_R4: assert property (@(posedge clk) disable iff (srst)
        accept |=> !accept);

    assert_reset_clears_R6: assert property (@(posedge clk)
        srst |=> (!valid_out && dout_zero));

endmodule

bind cic_interp cic_interp_chk #(.RMAX(RMAX)) u_chk (
    .clk(clk), .srst(srst), .ready(ready), .valid_out(valid_out),
    .accept(accept), .dout_zero(data_out == '0)
);

// File: tb/cic_interp_tb.sv
`timescale 1ns/1ps
module cic_interp_tb;

    localparam int DW   = 16;
    localparam int N    = 3;
    localparam int M    = 2;
    localparam int RMAX = 8;

    function automatic int growth();
        longint p = 1;
        int g = 0;
        for (int i = 0; i < N; i++) p = p * (RMAX * M);
        p = p / RMAX;
        while ((longint'(1) << g) < p) g++;
        return g;
    endfunction

    localparam int IW = DW + growth();

    logic          clk = 1'b0;
    logic          srst = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          valid_in = 1'b0;
    logic [11:0]   rate_in = 12'd8;
    logic          ready, ready_tr, valid_out, valid_tr;
    logic [IW-1:0] data_out;
    logic [DW-1:0] data_tr;

    always #2.5 clk = ~clk;

    cic_interp #(.DW(DW), .N(N), .M(M), .RMAX(RMAX), .VAR_RATE(1), .R_FIX(RMAX),
                 .FULL_PREC(1)) u_dut (
        .clk(clk), .srst(srst), .data_in(data_in), .valid_in(valid_in),
        .rate_in(rate_in), .ready(ready), .data_out(data_out), .valid_out(valid_out));

    cic_interp #(.DW(DW), .N(N), .M(M), .RMAX(RMAX), .VAR_RATE(1), .R_FIX(RMAX),
                 .FULL_PREC(0)) u_dut_tr (
        .clk(clk), .srst(srst), .data_in(data_in), .valid_in(valid_in),
        .rate_in(rate_in), .ready(ready_tr), .data_out(data_tr), .valid_out(valid_tr));

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    longint cdly[N][M];
    longint acc[N];
    longint exp_v[$];
    int     exp_c[$];
    bit     exp_rdy_prev = 0;
    int     lo_from = -1, lo_to = -2;
    bit     last_acc;

    function automatic int clampr(int r);
        if (r == 0) return 1;
        if (r > RMAX) return RMAX;
        return r;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            acc[i] = 0;
            for (int j = 0; j < M; j++) cdly[i][j] = 0;
        end
    endtask

    task automatic model_push(input longint x, input int r, input int t);
        longint c, y, v;
        c = x;
        for (int i = 0; i < N; i++) begin
            y = c - cdly[i][M-1];
            for (int j = M - 1; j > 0; j--) cdly[i][j] = cdly[i][j-1];
            cdly[i][0] = c;
            c = y;
        end
        for (int k = 0; k < r; k++) begin
            v = (k == 0) ? c : 0;
            for (int i = 0; i < N; i++) begin
                acc[i] = acc[i] + v;
                v = acc[i];
            end
            exp_v.push_back(v);
            exp_c.push_back(t + 2 + k);
        end
    endtask

    task automatic chk(input bit ok, input string what, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", tag, what, cyc, act, expv);
        end
    endtask

    // one clock cycle of stimulus and checking
    task automatic cycle(input bit v, input logic [DW-1:0] x, input int r, input bit rst);
        bit acc_now, er;
        logic [IW-1:0] e;
        @(negedge clk);
        srst = rst; valid_in = v; data_in = x; rate_in = 12'(r);
        #1;
        acc_now = v && exp_rdy_prev && !rst;
        er = !rst && !acc_now && !(cyc >= lo_from && cyc <= lo_to);
        total++;
        if (ready !== er) begin
            bad++;
            $display("FAIL R4 ready cycle %0d actual=%0b expected=%0b", cyc, ready, er);
        end
        if (exp_c.size() > 0 && exp_c[0] == cyc) begin
            e = exp_v[0][IW-1:0];
            chk(valid_out === 1'b1, "R3 valid_out", longint'(valid_out), 1);
            chk(data_out === e, "data_out", longint'($signed(data_out)), longint'($signed(e)));
            total++;
            if (data_tr !== e[IW-1 -: DW] || valid_tr !== 1'b1) begin
                bad++;
                $display("FAIL R8 truncated cycle %0d actual=%0d expected=%0d", cyc,
                         $signed(data_tr), $signed(e[IW-1 -: DW]));
            end
            void'(exp_v.pop_front());
            void'(exp_c.pop_front());
        end else begin
            chk(valid_out === 1'b0, "R3 valid_out idle", longint'(valid_out), 0);
        end
        if (acc_now) begin
            model_push(longint'($signed(x)), clampr(r), cyc);
            lo_from = cyc + 1;
            lo_to   = cyc + clampr(r) - 1;
        end
        if (rst) begin
            while (exp_c.size() > 0 && exp_c[$] > cyc) begin
                void'(exp_c.pop_back());
                void'(exp_v.pop_back());
            end
            model_clear();
            lo_to = -2;
        end
        last_acc = acc_now;
        exp_rdy_prev = er;
        cyc++;
    endtask

    // hold valid_in until the sample is taken
    task automatic send(input logic [DW-1:0] x, input int r);
        last_acc = 0;
        while (!last_acc) cycle(1'b1, x, r, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, '0, RMAX, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        // R6: reset state
        tag = "R6";
        cycle(1'b0, '0, 8, 1'b1);
        cycle(1'b0, '0, 8, 1'b1);
        cycle(1'b0, '0, 8, 1'b0);
        chk(valid_out === 1'b0 && data_out === '0, "R6 reset outputs", longint'(data_out), 0);
        chk(ready === 1'b1, "R6 ready after reset", longint'(ready), 1);

        // R1: impulse response then zeros
        tag = "R1";
        send(16'sd1000, 8);
        for (int i = 0; i < 6; i++) send('0, 8);
        idle(3);

        // R1: varied samples at fixed rate, valid held high (R2: refused offers)
        tag = "R2";
        for (int i = 0; i < 40; i++) send(DW'($urandom), 8);

        // R5: runtime rate changes, including clamped values
        tag = "R5";
        send(16'sd1234, 1); send(-16'sd500, 1); send(16'sd77, 3);
        send(16'sd3000, 0); send(-16'sd3000, 15); send(16'sd42, 5);
        for (int i = 0; i < 30; i++) send(DW'($urandom), int'($urandom_range(0, 12)));

        // R2: pulses offered while busy, data must not disturb the output
        tag = "R2";
        send(16'sd900, 8);
        cycle(1'b1, 16'sd32767, 8, 1'b0);
        cycle(1'b1, -16'sd32768, 2, 1'b0);
        cycle(1'b0, '0, 8, 1'b0);
        cycle(1'b1, 16'sd12345, 1, 1'b0);
        idle(10);

        // R6: reset in the middle of a burst, then resume at another rate
        tag = "R6";
        send(16'sd20000, 8);
        send(-16'sd15000, 8);
        cycle(1'b0, '0, 8, 1'b0);
        cycle(1'b0, '0, 8, 1'b0);
        cycle(1'b1, 16'sd5, 8, 1'b1);
        cycle(1'b0, '0, 8, 1'b0);
        chk(valid_out === 1'b0 && data_out === '0, "R6 cleared mid burst", longint'(data_out), 0);
        send(16'sd700, 4);
        for (int i = 0; i < 5; i++) send(DW'($urandom), 6);
        idle(4);

        // R7: full-scale DC input settles at -2^15 * 512
        tag = "R7";
        cycle(1'b0, '0, 8, 1'b1);
        for (int i = 0; i < 12; i++) send(-16'sd32768, 8);
        idle(12);
        for (int i = 0; i < 10; i++) send(16'sd32767, 8);
        for (int i = 0; i < 10; i++) send((i % 2) ? 16'sd32767 : -16'sd32768, 8);
        idle(12);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule